// File: doc/BRIEF.md
# Pipelined Quadratic Hyperbolic-Tangent Unit

This block gives a fixed-point estimate of tanh(x) for a stream of samples, one per clock. It fits a quadratic piece to each side of zero: x·(1 − x/4) for positive inputs and x·(1 + x/4) for negative inputs. Outside the open interval (−2, 2) the output is clamped to ±1. The result is a smooth odd curve whose absolute error against the true tanh stays below a few percent. It serves as the shared nonlinearity after a bank of multiply-accumulate units, where sums arrive serially and each needs its activation applied without stalling.

Samples are 18-bit two's complement numbers with 12 fractional bits, and each comes with a valid strobe. Two multipliers run side by side in the same stage: one forms the linear term and one forms the square term. Every sample therefore passes through a fixed five-register pipeline with no back-pressure. The output register holds its value between results.

Top module: `tanh_quad_approx`

## Requirements
- R1: While reset is asserted and after it is released, before any sample emerges, `outValid` is 0 and `outSample` is 0.
- R2: `outValid` equals `inValid` delayed by exactly five clock edges. A sample captured on edge n is presented on the outputs after edge n+4, counting the capture edge as the first of the five.
- R3: A new sample may be accepted on every clock. Back-to-back samples each yield their own independent result in order.
- R4: Input and output use two's complement with 12 fractional bits, so 1.0 is the code 4096. An input of 4096 gives 3072 (0.75).
- R5: An input code of at least 8192 gives 4096. An input code of at most −8192 gives −4096.
- R6: For an input code x with 0 ≤ x < 8192, the output is floor((4096·x − x·floor(x/4)) / 4096), capped at 4096.
- R7: For an input code x with −8192 < x < 0, the output is floor((4096·x + x·floor(x/4)) / 4096), capped at −4096. Both floors round toward minus infinity.
- R8: Input 0 gives 0. Inputs 8192 and −8192 give 4096 and −4096, so both branches meet the clamp.
- R9: Every output code lies within [−4096, 4096], and a non-negative input never yields a negative output.
- R10: When `inValid` is low, `inSample` has no effect. In any cycle where `outValid` is low, `outSample` keeps its previous value.
- R11: For every input, the output differs from tanh(x) by less than 0.045 in absolute value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe; `inSample` is captured on the edge where this is high |
| inSample | input | 18 | Signed input, 12 fractional bits |
| outValid | output | 1 | High for one cycle per emerging result |
| outSample | output | 18 | Signed approximation of tanh, 12 fractional bits, held between results |

## Verification
A dense back-to-back ramp across both quadratic pieces and past both clamp points shows that positive and negative sides use opposite square-term signs. It also shows that consecutive samples do not bleed into each other. Isolated samples at 0, ±1, ±8191, ±8192 and the extreme codes separate the clamp decision from the quadratic arithmetic and expose the floor rounding near the knee. A pattern that alternates valid and idle cycles, with garbage data on the idle cycles, shows the strobe alignment and the held output. A wide sweep compared against the real tanh bounds the curve's accuracy.

// File: rtl/tanhq_pkg.sv
package tanhq_pkg;

  // Number of register stages between inSample and outSample.
  localparam int STAGES = 5;

  // Per-stage load strobes sent from control to datapath.
  typedef struct packed {
    logic capture;
    logic prep;
    logic mult;
    logic sum;
    logic emit;
  } stageLoad_t;

endpackage

// File: rtl/tanhq_ctrl.sv
module tanhq_ctrl
  import tanhq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output stageLoad_t load,
  output logic       outValid
);

  logic [STAGES-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  // Each stage loads only when a live sample enters it.
  always_comb begin
    load.capture = inValid;
    load.prep    = vldPipe[0];
    load.mult    = vldPipe[1];
    load.sum     = vldPipe[2];
    load.emit    = vldPipe[3];
  end

  assign outValid = vldPipe[STAGES-1];

endmodule

// File: rtl/tanhq_datapath.sv
module tanhq_datapath
  import tanhq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageLoad_t               load,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [DATA_W-1:0] outSample
);

  localparam int PROD_W     = 2 * DATA_W;
  localparam int SUM_W      = PROD_W + 1;
  localparam int QUAD_SHIFT = 2;
  localparam int ONE_I      = 1 << FRAC_W;

  localparam logic signed [DATA_W-1:0] ONE_D   = DATA_W'(ONE_I);
  localparam logic signed [DATA_W-1:0] TWO_D   = DATA_W'(2 * ONE_I);
  localparam logic signed [DATA_W-1:0] LIN_G   = DATA_W'(ONE_I);
  localparam logic signed [SUM_W-1:0]  ONE_S   = SUM_W'(ONE_I);

  // Stage 1: capture
  logic signed [DATA_W-1:0] xR1;
  // Stage 2: quarter term and range flags
  logic signed [DATA_W-1:0] xR2, qR2;
  logic negR2, satPosR2, satNegR2;
  // Stage 3: two parallel products
  logic signed [PROD_W-1:0] linP, sqP;
  logic negR3, satPosR3, satNegR3;
  // Stage 4: combined sum
  logic signed [SUM_W-1:0] sumR;
  logic satPosR4, satNegR4;
  // Stage 5: output register
  logic signed [DATA_W-1:0] outR;

  always_ff @(posedge clk) begin
    if (load.capture) xR1 <= inSample;
  end

  always_ff @(posedge clk) begin
    if (load.prep) begin
      xR2      <= xR1;
      qR2      <= xR1 >>> QUAD_SHIFT;
      negR2    <= xR1[DATA_W-1];
      satPosR2 <= (xR1 >= TWO_D);
      satNegR2 <= (xR1 <= -TWO_D);
    end
  end

  // Linear path and square path run in the same stage.
  always_ff @(posedge clk) begin
    if (load.mult) begin
      linP     <= $signed({{DATA_W{xR2[DATA_W-1]}}, xR2}) *
                  $signed({{DATA_W{LIN_G[DATA_W-1]}}, LIN_G});
      sqP      <= $signed({{DATA_W{xR2[DATA_W-1]}}, xR2}) *
                  $signed({{DATA_W{qR2[DATA_W-1]}}, qR2});
      negR3    <= negR2;
      satPosR3 <= satPosR2;
      satNegR3 <= satNegR2;
    end
  end

  logic signed [SUM_W-1:0] linWide, sqWide;
  assign linWide = $signed({linP[PROD_W-1], linP});
  assign sqWide  = $signed({sqP[PROD_W-1], sqP});

  always_ff @(posedge clk) begin
    if (load.sum) begin
      sumR     <= negR3 ? (linWide + sqWide) : (linWide - sqWide);
      satPosR4 <= satPosR3;
      satNegR4 <= satNegR3;
    end
  end

  logic signed [SUM_W-1:0]  scaled;
  logic signed [DATA_W-1:0] nextOut;

  always_comb begin
    scaled = sumR >>> FRAC_W;
    if (satPosR4)               nextOut = ONE_D;
    else if (satNegR4)          nextOut = -ONE_D;
    else if (scaled > ONE_S)    nextOut = ONE_D;
    else if (scaled < -ONE_S)   nextOut = -ONE_D;
    else                        nextOut = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outR <= '0;
    else if (load.emit) outR <= nextOut;
  end

  assign outSample = outR;

endmodule

// File: rtl/tanh_quad_approx.sv
module tanh_quad_approx
  import tanhq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample
);

  stageLoad_t load;

  tanhq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .load     (load),
    .outValid (outValid)
  );

  tanhq_datapath #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .load      (load),
    .inSample  (inSample),
    .outSample (outSample)
  );

endmodule

// File: rtl/tanh_quad_approx_chk.sv
module tanh_quad_approx_chk
  import tanhq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int FRAC_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inSample,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outSample
);

  localparam int ONE_I = 1 << FRAC_W;
  localparam logic signed [DATA_W-1:0] ONE_D = DATA_W'(ONE_I);
  localparam logic signed [DATA_W-1:0] TWO_D = DATA_W'(2 * ONE_I);

  // Edges seen since reset release, saturating at STAGES.
  logic [3:0] sinceRst;
  logic warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst < STAGES) sinceRst <= sinceRst + 4'd1;
  end
  assign warm = (sinceRst >= STAGES);

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, 5)));

  // R5
  sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(inSample, 5) >= TWO_D)) |-> (outSample == ONE_D));

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(inSample, 5) <= -TWO_D)) |-> (outSample == -ONE_D));

  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(inSample, 5) == '0)) |-> (outSample == '0));

  // R9
  out_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSample <= ONE_D) && (outSample >= -ONE_D));

  // R9
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && !$past(inSample[DATA_W-1], 5)) |-> !outSample[DATA_W-1]);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample));

endmodule

bind tanh_quad_approx tanh_quad_approx_chk #(
  .DATA_W (DATA_W),
  .FRAC_W (FRAC_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inSample  (inSample),
  .outValid  (outValid),
  .outSample (outSample)
);

// File: tb/sim_tanh_quad_approx.sv
module sim_tanh_quad_approx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [17:0] inSample = '0;
  logic outValid;
  logic signed [17:0] outSample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side history of what was driven, oldest at index 4.
  bit    hV[5];
  int    hX[5];
  string hTag[5];
  int    lastExp = 0;

  always #4 clk = ~clk;

  tanh_quad_approx u0 (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSample  (inSample),
    .outValid  (outValid),
    .outSample (outSample)
  );

  function automatic int refTanh(int x);
    longint lin;
    longint q;
    longint s;
    longint r;
    if (x >= 8192)  return 4096;
    if (x <= -8192) return -4096;
    lin = longint'(x) * 4096;
    q   = longint'(x >>> 2);
    s   = (x < 0) ? (lin + longint'(x) * q) : (lin - longint'(x) * q);
    r   = s >>> 12;
    if (r > 4096)  r = 4096;
    if (r < -4096) r = -4096;
    return int'(r);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock of stimulus: check the output due now, then drive the next input.
  task automatic step(bit v, int x, string tag);
    int  exp;
    real t;
    real err;
    @(negedge clk);
    chk(outValid == hV[4], "R2", int'(outValid), int'(hV[4]));
    if (hV[4]) begin
      exp = refTanh(hX[4]);
      chk(int'(outSample) == exp, hTag[4], int'(outSample), exp);
      chk((outSample <= 18'sd4096) && (outSample >= -18'sd4096) &&
          !(hX[4] >= 0 && outSample < 0), "R9", int'(outSample), exp);
      if (hTag[4] == "R11") begin
        t   = $tanh(real'(hX[4]) / 4096.0);
        err = real'(outSample) / 4096.0 - t;
        if (err < 0.0) err = -err;
        chk(err < 0.045, "R11", int'(outSample), int'(t * 4096.0));
      end
      lastExp = exp;
    end else begin
      chk(int'(outSample) == lastExp, "R10", int'(outSample), lastExp);
    end
    for (int i = 4; i > 0; i--) begin
      hV[i] = hV[i-1]; hX[i] = hX[i-1]; hTag[i] = hTag[i-1];
    end
    hV[0] = v; hX[0] = x; hTag[0] = tag;
    inValid  = v;
    inSample = 18'(x);
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) step(1'b0, 0, "R10");
  endtask

  task automatic testReset();
    for (int i = 0; i < 5; i++) hV[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(outSample == '0, "R1", int'(outSample), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(outSample == '0, "R1", int'(outSample), 0);
  endtask

  task automatic testLatency();
    // R4: 1.0 maps to 0.75; R2 alignment checked every cycle in step
    step(1'b1, 4096, "R4");
    flush();
    step(1'b1, -4096, "R4");
    flush();
  endtask

  task automatic testSaturation();
    step(1'b1, 8193, "R5");
    step(1'b1, 20000, "R5");
    step(1'b1, 131071, "R5");
    step(1'b1, -8193, "R5");
    step(1'b1, -131072, "R5");
    step(1'b1, -50000, "R5");
    flush();
  endtask

  task automatic testExactPoints();
    step(1'b1, 0, "R8");
    step(1'b1, 8192, "R8");
    step(1'b1, -8192, "R8");
    step(1'b1, 8191, "R6");
    step(1'b1, -8191, "R7");
    step(1'b1, 1, "R6");
    step(1'b1, -1, "R7");
    step(1'b1, 3, "R6");
    step(1'b1, -5, "R7");
    flush();
  endtask

  task automatic testRamp();
    // R3: back-to-back across both pieces and both clamps
    for (int x = -12000; x <= 12000; x += 97)
      step(1'b1, x, (x < 0) ? "R7" : "R6");
    step(1'b1, 6000, "R3");
    step(1'b1, -6000, "R3");
    step(1'b1, 6000, "R3");
    flush();
  endtask

  task automatic testGaps();
    // R10: idle cycles carry garbage that must not show up
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) step(1'b1, (i * 523) - 9000, "R3");
      else            step(1'b0, 77777 - i * 1111, "R10");
    end
    flush();
  endtask

  task automatic testAccuracy();
    for (int x = -20000; x <= 20000; x += 37) step(1'b1, x, "R11");
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testLatency();
    testSaturation();
    testExactPoints();
    testRamp();
    testGaps();
    testAccuracy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule